// File: doc/BRIEF.md
# Canonical Address Checker with Tag Ignore

This stage sits between address generation and translation. It accepts a 64-bit virtual address with a valid strobe. With that address it also samples two configuration inputs. The first selects how many address bits are implemented: 48 bits, or 57 bits for five-level paging. The second selects which upper bits may carry software tags. The stage then checks that the address is canonical for the selected modes.

One cycle later the stage returns three things. The first is the cleaned address, made by sign extension from the highest implemented bit. The second is the ignored tag bits, right-justified. The third is a general-protection fault flag, raised when the address cannot be canonical, so that no page-table lookup is tried for it.

Top module: `canon_addr_stage`

## Requirements
- R1: `valid_o` is high exactly one cycle after `valid_i` is high, and low otherwise. `fault_o` is high only together with `valid_o`.
- R2: With `width_mode_i`=0 (48-bit) and no tag ignore (`tag_mode_i`=0), the address faults unless bits 63..48 all equal bit 47.
- R3: With `width_mode_i`=1 (57-bit) and no tag ignore, the address faults unless bits 63..57 all equal bit 56.
- R4: With `tag_mode_i`=1 (middle ignore), only bit 63 is compared against the top implemented bit (47 or 56). The bits between them are not checked. `tag_o` returns bits 62..48 (48-bit) or bits 62..57 (57-bit) right-justified, zero-filled.
- R5: With `tag_mode_i`=2 (top-byte ignore), bits 63..56 are never checked and `tag_o` returns bits 63..56 in its low 8 bits. In 48-bit width, bits 55..48 must still equal bit 47. In 57-bit width, no fault can occur.
- R6: On a non-faulting result, every `addr_o` bit above the top implemented bit equals that bit, and all lower bits pass through unchanged.
- R7: On a faulting result, `addr_o` and `tag_o` are zero.
- R8: With `tag_mode_i`=0, or the reserved code 3 (which behaves as 0), `tag_o` is zero.
- R9: The mode inputs matter only on a cycle with `valid_i` high. While `valid_i` is low, `addr_o` and `tag_o` hold their values, and mode changes leave them untouched.
- R10: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Address strobe |
| addr_i | input | 64 | Virtual address |
| width_mode_i | input | 1 | 0: 48-bit, 1: 57-bit implemented width |
| tag_mode_i | input | 2 | 0: none, 1: middle ignore, 2: top-byte ignore, 3: as 0 |
| valid_o | output | 1 | Result valid, one cycle after strobe |
| fault_o | output | 1 | General-protection fault for a non-canonical address |
| addr_o | output | 64 | Sign-extended cleaned address |
| tag_o | output | 15 | Ignored bits, right-justified |

## Verification
Directed addresses test the corner cases one at a time. An address with one stray bit just above bit 47 separates the strict 48-bit check from the 57-bit check. A clean low half with only bit 63 flipped separates middle-ignore mode from top-byte-ignore mode. A value confined to bits 55..48 shows that top-byte ignore still checks those bits at 48-bit width. Random addresses then run across all width and tag codes, including the reserved code. Half of them are forced to be sign-extended, so both faulting and passing results occur often. Idle cycles with shifting mode inputs show that captured results are not disturbed.

// File: rtl/addr_chk_pkg.sv
package addr_chk_pkg;
  typedef enum logic {
    WIDTH_48 = 1'b0,
    WIDTH_57 = 1'b1
  } width_mode_e;

  typedef enum logic [1:0] {
    TAG_NONE = 2'd0,
    TAG_MID  = 2'd1,
    TAG_TOP  = 2'd2,
    TAG_RSVD = 2'd3
  } tag_mode_e;
endpackage

// File: rtl/canon_mask.sv
// Per-bit selection of which upper bits are compared against the top implemented bit.
module canon_mask
  import addr_chk_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int LO_MSB  = 47,
  parameter int HI_MSB  = 56,
  parameter int TOP_LSB = 56
) (
  input  width_mode_e         width_i,
  input  tag_mode_e           tag_i,
  output logic [ADDR_W-1:0]   chk_mask_o
);
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    localparam bit AboveLo = (i > LO_MSB);
    localparam bit AboveHi = (i > HI_MSB);
    localparam bit IsTop   = (i == ADDR_W - 1);
    localparam bit BelowTb = (i < TOP_LSB);
    logic above;
    assign above = (width_i == WIDTH_57) ? AboveHi : AboveLo;
    always_comb begin
      unique case (tag_i)
        TAG_MID: chk_mask_o[i] = above & IsTop;
        TAG_TOP: chk_mask_o[i] = above & BelowTb;
        default: chk_mask_o[i] = above;
      endcase
    end
  end
endmodule

// File: rtl/canon_eval.sv
// Fault detection and sign-extension cleaning.
module canon_eval
  import addr_chk_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LO_MSB = 47,
  parameter int HI_MSB = 56
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  width_mode_e       width_i,
  input  logic [ADDR_W-1:0] chk_mask_i,
  output logic              fault_o,
  output logic [ADDR_W-1:0] clean_o
);
  localparam logic [ADDR_W-1:0] ExtLo = ~((ADDR_W'(1) << (LO_MSB + 1)) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] ExtHi = ~((ADDR_W'(1) << (HI_MSB + 1)) - ADDR_W'(1));

  logic              sign_bit;
  logic [ADDR_W-1:0] ext_mask;
  logic [ADDR_W-1:0] sign_rep;

  assign sign_bit = (width_i == WIDTH_57) ? addr_i[HI_MSB] : addr_i[LO_MSB];
  assign ext_mask = (width_i == WIDTH_57) ? ExtHi : ExtLo;
  assign sign_rep = {ADDR_W{sign_bit}};
  assign fault_o  = |((addr_i ^ sign_rep) & chk_mask_i);
  assign clean_o  = (addr_i & ~ext_mask) | (sign_rep & ext_mask);
endmodule

// File: rtl/tag_extract.sv
// Right-justified extraction of the ignored bits.
module tag_extract
  import addr_chk_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int LO_MSB  = 47,
  parameter int HI_MSB  = 56,
  parameter int TOP_LSB = 56,
  parameter int TAG_W   = ADDR_W - LO_MSB - 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  width_mode_e       width_i,
  input  tag_mode_e         tag_i,
  output logic [TAG_W-1:0]  tag_o
);
  localparam int MidLoW = ADDR_W - LO_MSB - 2;
  localparam int MidHiW = ADDR_W - HI_MSB - 2;
  localparam int TopW   = ADDR_W - TOP_LSB;

  localparam logic [ADDR_W-1:0] MskMidLo = (ADDR_W'(1) << MidLoW) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] MskMidHi = (ADDR_W'(1) << MidHiW) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] MskTop   = (ADDR_W'(1) << TopW) - ADDR_W'(1);

  logic [ADDR_W-1:0] shifted;
  logic              unused_hi;

  always_comb begin
    unique case (tag_i)
      TAG_MID: shifted = (width_i == WIDTH_57) ? ((addr_i >> (HI_MSB + 1)) & MskMidHi)
                                               : ((addr_i >> (LO_MSB + 1)) & MskMidLo);
      TAG_TOP: shifted = (addr_i >> TOP_LSB) & MskTop;
      default: shifted = '0;
    endcase
  end

  assign tag_o     = shifted[TAG_W-1:0];
  assign unused_hi = ^shifted[ADDR_W-1:TAG_W];
endmodule

// File: rtl/canon_addr_stage.sv
module canon_addr_stage
  import addr_chk_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int LO_MSB  = 47,
  parameter int HI_MSB  = 56,
  parameter int TOP_LSB = 56,
  localparam int TAG_W  = ADDR_W - LO_MSB - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              width_mode_i,
  input  logic [1:0]        tag_mode_i,
  output logic              valid_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [TAG_W-1:0]  tag_o
);
  width_mode_e       width_s;
  tag_mode_e         tag_s;
  logic [ADDR_W-1:0] chk_mask;
  logic              fault_c;
  logic [ADDR_W-1:0] clean_c;
  logic [TAG_W-1:0]  tag_c;

  assign width_s = width_mode_e'(width_mode_i);
  assign tag_s   = tag_mode_e'(tag_mode_i);

  canon_mask #(.ADDR_W(ADDR_W), .LO_MSB(LO_MSB), .HI_MSB(HI_MSB), .TOP_LSB(TOP_LSB)) u_mask (
    .width_i(width_s), .tag_i(tag_s), .chk_mask_o(chk_mask)
  );

  canon_eval #(.ADDR_W(ADDR_W), .LO_MSB(LO_MSB), .HI_MSB(HI_MSB)) u_eval (
    .addr_i(addr_i), .width_i(width_s), .chk_mask_i(chk_mask),
    .fault_o(fault_c), .clean_o(clean_c)
  );

  tag_extract #(.ADDR_W(ADDR_W), .LO_MSB(LO_MSB), .HI_MSB(HI_MSB), .TOP_LSB(TOP_LSB),
                .TAG_W(TAG_W)) u_tag (
    .addr_i(addr_i), .width_i(width_s), .tag_i(tag_s), .tag_o(tag_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      fault_o <= 1'b0;
      addr_o  <= '0;
      tag_o   <= '0;
    end else begin
      valid_o <= valid_i;
      fault_o <= valid_i & fault_c;
      if (valid_i) begin
        addr_o <= fault_c ? '0 : clean_c;
        tag_o  <= fault_c ? '0 : tag_c;
      end
    end
  end

  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_fault_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> valid_o);
  p_fault_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (addr_o == '0 && tag_o == '0));
  p_upper_ext_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !fault_o) |->
      (addr_o[ADDR_W-1:TOP_LSB] == '0 || addr_o[ADDR_W-1:TOP_LSB] == '1));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(addr_o) && $stable(tag_o)));
endmodule

// File: tb/canon_addr_stage_tb.sv
`timescale 1ns/1ps
module canon_addr_stage_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] addr_i = '0;
  logic        width_mode_i = 1'b0;
  logic [1:0]  tag_mode_i = 2'd0;
  logic        valid_o, fault_o;
  logic [63:0] addr_o;
  logic [14:0] tag_o;

  int vectors = 0;
  int miscompares = 0;

  logic        e_valid = 0, e_fault = 0;
  logic [63:0] e_addr = '0;
  logic [14:0] e_tag = '0;
  logic        e_wm = 0;
  logic [1:0]  e_tm = 0;

  always #2.5 clk = ~clk;

  canon_addr_stage u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .addr_i(addr_i),
    .width_mode_i(width_mode_i), .tag_mode_i(tag_mode_i),
    .valid_o(valid_o), .fault_o(fault_o), .addr_o(addr_o), .tag_o(tag_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference: bit-by-bit rules as written in the requirements.
  task automatic model(input logic [63:0] a, input logic wm, input logic [1:0] tm,
                       output logic f, output logic [63:0] ca, output logic [14:0] t);
    int msb = wm ? 56 : 47;
    int j = 0;
    f = 0; ca = a; t = '0;
    for (int i = msb + 1; i < 64; i++) begin
      logic checked;
      if (tm == 2'd1)      checked = (i == 63);
      else if (tm == 2'd2) checked = (i < 56);
      else                 checked = 1'b1;
      if (checked && a[i] != a[msb]) f = 1;
      ca[i] = a[msb];
    end
    if (tm == 2'd1) begin
      for (int i = msb + 1; i < 63; i++) begin t[j] = a[i]; j++; end
    end else if (tm == 2'd2) begin
      for (int i = 56; i < 64; i++) begin t[j] = a[i]; j++; end
    end
    if (f) begin ca = '0; t = '0; end
  endtask

  function automatic string rule_of(input logic wm, input logic [1:0] tm);
    if (tm == 2'd1) return "R4";
    if (tm == 2'd2) return "R5";
    return wm ? "R3" : "R2";
  endfunction

  task automatic compare();
    string rf = rule_of(e_wm, e_tm);
    chk("R1 valid", {63'd0, valid_o}, {63'd0, e_valid});
    chk({rf, " fault"}, {63'd0, fault_o}, {63'd0, e_fault});
    if (e_valid) begin
      chk(e_fault ? "R7 addr" : "R6 addr", addr_o, e_addr);
      chk((e_tm == 2'd0 || e_tm == 2'd3) ? "R8 tag" : {rf, " tag"}, {49'd0, tag_o}, {49'd0, e_tag});
    end else begin
      chk("R9 hold addr", addr_o, e_addr);
      chk("R9 hold tag", {49'd0, tag_o}, {49'd0, e_tag});
    end
  endtask

  task automatic step(input logic v, input logic [63:0] a, input logic wm, input logic [1:0] tm);
    logic f; logic [63:0] ca; logic [14:0] t;
    @(negedge clk);
    compare();
    valid_i = v; addr_i = a; width_mode_i = wm; tag_mode_i = tm;
    e_valid = v;
    if (v) begin
      model(a, wm, tm, f, ca, t);
      e_fault = f; e_addr = ca; e_tag = t; e_wm = wm; e_tm = tm;
    end else begin
      e_fault = 0;
    end
  endtask

  function automatic logic [63:0] rnd_addr(input logic wm);
    logic [63:0] a = {$urandom, $urandom};
    int msb = wm ? 56 : 47;
    if ($urandom_range(1, 0) == 1)
      for (int i = msb + 1; i < 64; i++) a[i] = a[msb];
    if ($urandom_range(3, 0) == 0) a[63] = ~a[63];
    return a;
  endfunction

  initial begin
    #(5.0 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 valid", {63'd0, valid_o}, 64'd0);
    chk("R10 fault", {63'd0, fault_o}, 64'd0);
    chk("R10 addr", addr_o, 64'd0);
    chk("R10 tag", {49'd0, tag_o}, 64'd0);
    rst_ni = 1'b1;
    // R2: 48-bit strict
    step(1, 64'h0000_7fff_ffff_f000, 0, 0);
    step(1, 64'hffff_8000_0000_1234, 0, 0);
    step(1, 64'h0001_0000_0000_0040, 0, 0);
    // R3: same stray bit passes in 57-bit mode, bit 57 stray fails
    step(1, 64'h0001_0000_0000_0040, 1, 0);
    step(1, 64'h0200_0000_0000_0000, 1, 0);
    // R4: middle ignore, only bit 63 compared
    step(1, 64'h7abc_0000_1234_5678, 0, 1);
    step(1, 64'h8000_0000_0000_0001, 0, 1);
    step(1, 64'h7e00_0000_0000_0000, 1, 1);
    // R5: top-byte ignore
    step(1, 64'hff00_0000_0000_0010, 0, 2);
    step(1, 64'h0012_0000_0000_0000, 0, 2);
    step(1, 64'h5a12_3456_789a_bcde, 1, 2);
    // R8: reserved code behaves as no ignore
    step(1, 64'h0001_0000_0000_0000, 0, 3);
    step(1, 64'hffff_ffff_ffff_fff0, 0, 3);
    // R9: mode churn while idle
    step(1, 64'h7abc_0000_1234_5678, 0, 1);
    step(0, 64'h0, 1, 2);
    step(0, 64'hdead_beef_0000_0000, 0, 0);
    step(1, 64'h0000_0000_0000_0abc, 1, 3);
    // random sweep
    for (int n = 0; n < 4000; n++) begin
      logic wm = 1'($urandom_range(1, 0));
      step(1'($urandom_range(3, 0) != 0), rnd_addr(wm), wm, 2'($urandom_range(3, 0)));
    end
    step(0, 64'h0, 0, 0);
    step(0, 64'h0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule